// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and Completion Unit

This unit sits beside one CPU's interrupt interface and owns the bookkeeping for interrupts that the CPU has taken. It knows which interrupt is currently being serviced and at what priority. When the CPU reads the acknowledge strobe, the unit either hands over the best pending interrupt, if it is urgent enough to preempt the current one, or returns the spurious ID 1023. When the CPU writes an end-of-interrupt, the unit retires the named interrupt and, if needed, asks the pending logic to raise a level source again.

Every accepted interrupt records the ID that it preempted. This builds a linked stack that is threaded through a per-interrupt link table. Retiring the top of the stack pops back to the preempted interrupt, and its priority is fetched through a lookup port. Retiring an interrupt buried deeper in the stack removes it from the chain in place. The unit does this one link per clock and raises `busy` while it walks. Pending selection, the priority table and the register decode stay outside. The pending ID, its priority and the per-source attributes needed at completion come in on ports.

Top module: `ackc_unit`

## Requirements
- R1: After reset, `run_id` is 1023, `run_prio` is 0x100 (the idle value, bit PRIO_W set), `busy` is low, and no pulse output (`ack_valid`, `clr_valid`, `repend_valid`) is high. Every link entry reads as 1023.
- R2: An acknowledge is refused when `pend_id` is 1023 or not below NUM_IRQ, or when `pend_prio` is not strictly below `run_prio`. In that case, the cycle after the strobe shows `ack_valid`=1 with `ack_id`=1023, `clr_valid`=0, and the running ID and priority do not change.
- R3: An accepted acknowledge gives `ack_valid`=1 with `ack_id`=`pend_id` in the following cycle. From then on, `run_id` equals that ID and `run_prio` equals its `pend_prio`.
- R4: An accepted acknowledge pulses `clr_valid` with `clr_id` = the taken ID. `clr_mask` is all ones when `pend_model_1n`=1. Otherwise only bit CPU_IDX of `clr_mask` is set.
- R5: An end-of-interrupt takes `eoi_data[9:0]` as the ID and ignores all higher bits. It has no effect (no state change, no `repend_valid`) when that ID is at or above NUM_IRQ (this includes 1023), or when `run_id` is 1023.
- R6: An end-of-interrupt that is not ignored pulses `repend_valid` with `repend_id` = the ID in the following cycle, exactly when `cmp_is_level`=1 (1 = level-sensitive), `cmp_enabled`=1, `cmp_line_high`=1 and `cmp_targets_me`=1.
- R7: Completing the running ID restores the ID it preempted. `run_prio` then becomes `lkup_prio` for that ID, or 0x100 when the restored ID is 1023.
- R8: Completing an ID that is not the running one leaves `run_id` and `run_prio` unchanged and holds `busy` high while the chain is walked. The completed ID is removed from the chain, so later completions pop over it. An ID absent from the chain leaves the chain intact.
- R9: While `busy` is high, acknowledge and end-of-interrupt requests are ignored: no `ack_valid` is produced and no state changes.
- R10: When acknowledge and end-of-interrupt are requested in the same idle cycle, the acknowledge is served and the end-of-interrupt is dropped.
- R11: Nested acknowledges stack. Each accepted ID can be completed back, in reverse order, to the interrupt it preempted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Acknowledge read strobe |
| pend_id | input | 10 | Highest pending ID for this CPU (1023 = none) |
| pend_prio | input | PRIO_W | Priority of `pend_id` (lower is more urgent) |
| pend_model_1n | input | 1 | 1 = source uses 1-of-N handling, clear for all CPUs |
| ack_valid | output | 1 | Acknowledge result valid (one cycle) |
| ack_id | output | 10 | Returned ID, 1023 when refused |
| clr_valid | output | 1 | Pending-clear request pulse |
| clr_id | output | 10 | ID whose pending bit is cleared |
| clr_mask | output | NUM_CPU | CPUs for which to clear pending |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | Written word; bits [9:0] carry the ID |
| cmp_is_level | input | 1 | Completed source is level-sensitive |
| cmp_enabled | input | 1 | Completed source is enabled |
| cmp_line_high | input | 1 | Completed source's input is still asserted |
| cmp_targets_me | input | 1 | Completed source targets this CPU |
| repend_valid | output | 1 | Set-pending request pulse for a still-high level source |
| repend_id | output | 10 | ID to set pending again |
| lkup_id | output | 10 | ID whose priority is requested |
| lkup_prio | input | PRIO_W | Priority of `lkup_id`, combinational |
| busy | output | 1 | Chain walk in progress |
| run_id | output | 10 | Running interrupt ID (1023 = none) |
| run_prio | output | PRIO_W+1 | Running priority (0x100 = idle) |

## Verification
The bench instantiates NUM_IRQ=48, NUM_CPU=4 and CPU_IDX=2. This puts the implemented-count boundary at a value that is not a power of two. IDs 47 and 48 then fall on opposite sides of the range check, and the link table's index width reaches entries that do not exist. With four CPUs and this CPU in the middle position, a one-hot clear mask can be told apart from an all-CPU mask or a wrong bit. The priority table gives higher IDs lower values, so rising IDs nest naturally. Four- and five-deep chains then exercise multi-cycle walks, the busy window, and requests arriving during it.

// File: rtl/ackc_pkg.sv
package ackc_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] NO_IRQ = 10'h3FF;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_e;
endpackage

// File: rtl/ackc_link_store.sv
module ackc_link_store
    import ackc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  logic [ID_W-1:0] wr_link,
    input  logic [ID_W-1:0] rd_a_id,
    output logic [ID_W-1:0] rd_a_link,
    input  logic [ID_W-1:0] rd_b_id,
    output logic [ID_W-1:0] rd_b_link
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic [ID_W-1:0] link_q [NUM_IRQ];
    logic [ID_W-1:0] link_d [NUM_IRQ];

    always_comb begin
        link_d = link_q;
        if (wr_en && (wr_id < LIMIT)) begin
            link_d[wr_id[IDX_W-1:0]] = wr_link;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                link_q[i] <= NO_IRQ;
            end
        end else begin
            link_q <= link_d;
        end
    end

    assign rd_a_link = (rd_a_id < LIMIT) ? link_q[rd_a_id[IDX_W-1:0]] : NO_IRQ;
    assign rd_b_link = (rd_b_id < LIMIT) ? link_q[rd_b_id[IDX_W-1:0]] : NO_IRQ;

    // a stored link is either the end marker or a real implemented ID
    p_link_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_id < LIMIT) && ((wr_link == NO_IRQ) || (wr_link < LIMIT)));
endmodule

// File: rtl/ackc_ack_check.sv
module ackc_ack_check
    import ackc_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 8,
    parameter int CPU_IDX = 0,
    parameter int PRIO_W  = 8
) (
    input  logic [ID_W-1:0]    pend_id,
    input  logic [PRIO_W-1:0]  pend_prio,
    input  logic [PRIO_W:0]    run_prio,
    input  logic               model_1n,
    output logic               take,
    output logic [NUM_CPU-1:0] clr_mask
);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    assign take = (pend_id != NO_IRQ) && (pend_id < LIMIT)
               && ({1'b0, pend_prio} < run_prio);

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_mask
        assign clr_mask[g] = model_1n || (g == CPU_IDX);
    end
endmodule

// File: rtl/ackc_eoi_decode.sv
module ackc_eoi_decode
    import ackc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [31:0]     eoi_data,
    input  logic [ID_W-1:0] run_id,
    input  logic            cmp_is_level,
    input  logic            cmp_enabled,
    input  logic            cmp_line_high,
    input  logic            cmp_targets_me,
    output logic [ID_W-1:0] eoi_id,
    output logic            accept,
    output logic            is_top,
    output logic            repend
);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic [31-ID_W:0] data_hi_unused;
    assign data_hi_unused = eoi_data[31:ID_W];

    assign eoi_id = eoi_data[ID_W-1:0];
    assign accept = (eoi_id < LIMIT) && (run_id != NO_IRQ);
    assign is_top = (eoi_id == run_id);
    assign repend = accept && cmp_is_level && cmp_enabled
                 && cmp_line_high && cmp_targets_me;
endmodule

// File: rtl/ackc_unit.sv
module ackc_unit
    import ackc_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 8,
    parameter int CPU_IDX = 0,
    parameter int PRIO_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_req,
    input  logic [ID_W-1:0]    pend_id,
    input  logic [PRIO_W-1:0]  pend_prio,
    input  logic               pend_model_1n,
    output logic               ack_valid,
    output logic [ID_W-1:0]    ack_id,
    output logic               clr_valid,
    output logic [ID_W-1:0]    clr_id,
    output logic [NUM_CPU-1:0] clr_mask,
    input  logic               eoi_req,
    input  logic [31:0]        eoi_data,
    input  logic               cmp_is_level,
    input  logic               cmp_enabled,
    input  logic               cmp_line_high,
    input  logic               cmp_targets_me,
    output logic               repend_valid,
    output logic [ID_W-1:0]    repend_id,
    output logic [ID_W-1:0]    lkup_id,
    input  logic [PRIO_W-1:0]  lkup_prio,
    output logic               busy,
    output logic [ID_W-1:0]    run_id,
    output logic [PRIO_W:0]    run_prio
);
    localparam logic [ID_W-1:0]   LIMIT     = ID_W'(NUM_IRQ);
    localparam logic [PRIO_W:0]   PRIO_IDLE = {1'b1, {PRIO_W{1'b0}}};
    localparam logic [NUM_CPU-1:0] OWN_BIT  = NUM_CPU'(1) << CPU_IDX;

    typedef struct packed {
        walk_st_e             mode;
        logic [ID_W-1:0]      run_id;
        logic [PRIO_W:0]      run_prio;
        logic [ID_W-1:0]      walk_cur;
        logic [ID_W-1:0]      walk_tgt;
        logic                 ack_valid;
        logic [ID_W-1:0]      ack_id;
        logic                 clr_valid;
        logic [ID_W-1:0]      clr_id;
        logic [NUM_CPU-1:0]   clr_mask;
        logic                 rep_valid;
        logic [ID_W-1:0]      rep_id;
    } ctl_t;

    ctl_t s_q, s_d;

    logic               take;
    logic [NUM_CPU-1:0] ck_mask;
    logic [ID_W-1:0]    eoi_id;
    logic               eoi_accept, eoi_is_top, eoi_repend;
    logic               lw_en;
    logic [ID_W-1:0]    lw_id, lw_link;
    logic [ID_W-1:0]    rd_a_id, rd_a_link, rd_b_link;

    ackc_ack_check #(
        .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_IDX(CPU_IDX), .PRIO_W(PRIO_W)
    ) u_ack (
        .pend_id  (pend_id),
        .pend_prio(pend_prio),
        .run_prio (s_q.run_prio),
        .model_1n (pend_model_1n),
        .take     (take),
        .clr_mask (ck_mask)
    );

    ackc_eoi_decode #(.NUM_IRQ(NUM_IRQ)) u_eoi (
        .eoi_data      (eoi_data),
        .run_id        (s_q.run_id),
        .cmp_is_level  (cmp_is_level),
        .cmp_enabled   (cmp_enabled),
        .cmp_line_high (cmp_line_high),
        .cmp_targets_me(cmp_targets_me),
        .eoi_id        (eoi_id),
        .accept        (eoi_accept),
        .is_top        (eoi_is_top),
        .repend        (eoi_repend)
    );

    assign rd_a_id = (s_q.mode == ST_WALK) ? s_q.walk_cur : s_q.run_id;

    ackc_link_store #(.NUM_IRQ(NUM_IRQ)) u_links (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lw_en),
        .wr_id    (lw_id),
        .wr_link  (lw_link),
        .rd_a_id  (rd_a_id),
        .rd_a_link(rd_a_link),
        .rd_b_id  (s_q.walk_tgt),
        .rd_b_link(rd_b_link)
    );

    always_comb begin
        s_d           = s_q;
        s_d.ack_valid = 1'b0;
        s_d.clr_valid = 1'b0;
        s_d.rep_valid = 1'b0;
        lw_en         = 1'b0;
        lw_id         = s_q.walk_cur;
        lw_link       = s_q.run_id;
        unique case (s_q.mode)
            ST_IDLE: begin
                if (ack_req) begin
                    s_d.ack_valid = 1'b1;
                    if (take) begin
                        s_d.ack_id    = pend_id;
                        s_d.run_id    = pend_id;
                        s_d.run_prio  = {1'b0, pend_prio};
                        s_d.clr_valid = 1'b1;
                        s_d.clr_id    = pend_id;
                        s_d.clr_mask  = ck_mask;
                        lw_en         = 1'b1;
                        lw_id         = pend_id;
                        lw_link       = s_q.run_id;
                    end else begin
                        s_d.ack_id = NO_IRQ;
                    end
                end else if (eoi_req && eoi_accept) begin
                    s_d.rep_valid = eoi_repend;
                    s_d.rep_id    = eoi_id;
                    if (eoi_is_top) begin
                        s_d.run_id   = rd_a_link;
                        s_d.run_prio = (rd_a_link == NO_IRQ) ? PRIO_IDLE
                                                             : {1'b0, lkup_prio};
                    end else begin
                        s_d.mode     = ST_WALK;
                        s_d.walk_cur = s_q.run_id;
                        s_d.walk_tgt = eoi_id;
                    end
                end
            end
            ST_WALK: begin
                if (rd_a_link == NO_IRQ) begin
                    s_d.mode = ST_IDLE;
                end else if (rd_a_link == s_q.walk_tgt) begin
                    lw_en    = 1'b1;
                    lw_id    = s_q.walk_cur;
                    lw_link  = rd_b_link;
                    s_d.mode = ST_IDLE;
                end else begin
                    s_d.walk_cur = rd_a_link;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode      <= ST_IDLE;
            s_q.run_id    <= NO_IRQ;
            s_q.run_prio  <= PRIO_IDLE;
            s_q.walk_cur  <= NO_IRQ;
            s_q.walk_tgt  <= NO_IRQ;
            s_q.ack_valid <= 1'b0;
            s_q.ack_id    <= NO_IRQ;
            s_q.clr_valid <= 1'b0;
            s_q.clr_id    <= NO_IRQ;
            s_q.clr_mask  <= '0;
            s_q.rep_valid <= 1'b0;
            s_q.rep_id    <= NO_IRQ;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_valid    = s_q.ack_valid;
    assign ack_id       = s_q.ack_id;
    assign clr_valid    = s_q.clr_valid;
    assign clr_id       = s_q.clr_id;
    assign clr_mask     = s_q.clr_mask;
    assign repend_valid = s_q.rep_valid;
    assign repend_id    = s_q.rep_id;
    assign lkup_id      = rd_a_link;
    assign busy         = (s_q.mode == ST_WALK);
    assign run_id       = s_q.run_id;
    assign run_prio     = s_q.run_prio;

    // walk length monitor: the chain can never hold more links than IDs
    logic [ID_W:0] walk_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            walk_cnt_q <= '0;
        end else begin
            walk_cnt_q <= walk_cnt_q + 1'b1;
        end
    end

    p_walk_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_cnt_q <= (ID_W+1)'(NUM_IRQ));
    p_walk_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(run_id) && $stable(run_prio));
    p_busy_blocks_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack_valid && !clr_valid && !repend_valid);
    p_refused_keeps_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id == NO_IRQ) |-> $stable(run_id) && !clr_valid);
    p_taken_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != NO_IRQ) |-> (run_id == ack_id) && clr_valid
                                             && (clr_id == ack_id));
    p_clr_mask_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> (clr_mask == {NUM_CPU{1'b1}}) || (clr_mask == OWN_BIT));
    p_idle_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == NO_IRQ) |-> (run_prio == PRIO_IDLE));
    p_repend_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        repend_valid |-> (repend_id < LIMIT) && !clr_valid);
endmodule

// File: tb/tb_ackc_unit.sv
`timescale 1ns/1ps
module tb_ackc_unit;
    localparam int NUM_IRQ = 48;
    localparam int NUM_CPU = 4;
    localparam int CPU_IDX = 2;
    localparam int PRIO_W  = 8;
    localparam logic [9:0] SPUR = 10'h3FF;
    localparam logic [8:0] IDLE_P = 9'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic ack_req = 0, pend_model_1n = 0, eoi_req = 0;
    logic [9:0] pend_id = SPUR;
    logic [7:0] pend_prio = 8'hFF;
    logic [31:0] eoi_data = 0;
    logic cmp_is_level = 0, cmp_enabled = 0, cmp_line_high = 0, cmp_targets_me = 0;
    logic ack_valid, clr_valid, repend_valid, busy;
    logic [9:0] ack_id, clr_id, repend_id, lkup_id, run_id;
    logic [NUM_CPU-1:0] clr_mask;
    logic [7:0] lkup_prio;
    logic [8:0] run_prio;

    int total = 0;
    int bad = 0;

    function automatic logic [7:0] prio_of(input logic [9:0] id);
        if (id >= 10'(NUM_IRQ)) return 8'hFF;
        return 8'(240 - 4 * int'(id));
    endfunction

    assign lkup_prio = prio_of(lkup_id);

    ackc_unit #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_IDX(CPU_IDX), .PRIO_W(PRIO_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ack_req(ack_req), .pend_id(pend_id), .pend_prio(pend_prio), .pend_model_1n(pend_model_1n),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .clr_valid(clr_valid), .clr_id(clr_id), .clr_mask(clr_mask),
        .eoi_req(eoi_req), .eoi_data(eoi_data),
        .cmp_is_level(cmp_is_level), .cmp_enabled(cmp_enabled),
        .cmp_line_high(cmp_line_high), .cmp_targets_me(cmp_targets_me),
        .repend_valid(repend_valid), .repend_id(repend_id),
        .lkup_id(lkup_id), .lkup_prio(lkup_prio),
        .busy(busy), .run_id(run_id), .run_prio(run_prio));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_ack(input logic [9:0] id, input logic model);
        @(negedge clk);
        ack_req = 1; pend_id = id; pend_prio = prio_of(id); pend_model_1n = model;
        @(negedge clk);
        ack_req = 0;
    endtask

    task automatic do_eoi(input logic [31:0] data, input logic [3:0] flags);
        @(negedge clk);
        eoi_req = 1; eoi_data = data;
        {cmp_is_level, cmp_enabled, cmp_line_high, cmp_targets_me} = flags;
        @(negedge clk);
        eoi_req = 0;
        {cmp_is_level, cmp_enabled, cmp_line_high, cmp_targets_me} = 4'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic chk_run(input string req, input logic [9:0] exp_id);
        chk(req, 32'(run_id), 32'(exp_id));
        chk(req, 32'(run_prio), (exp_id == SPUR) ? 32'(IDLE_P) : 32'(prio_of(exp_id)));
    endtask

    typedef struct packed {
        logic        is_ack;
        logic [31:0] arg;
        logic [9:0]  exp_ack;
        logic [9:0]  exp_run;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'd1023, 10'd1023, 10'd1023},
        '{1'b1, 32'd5,    10'd5,    10'd5},
        '{1'b1, 32'd3,    10'd1023, 10'd5},
        '{1'b1, 32'd5,    10'd1023, 10'd5},
        '{1'b1, 32'd10,   10'd10,   10'd10},
        '{1'b1, 32'd20,   10'd20,   10'd20},
        '{1'b0, 32'd20,   10'd1023, 10'd10},
        '{1'b0, 32'd10,   10'd1023, 10'd5},
        '{1'b0, 32'd5,    10'd1023, 10'd1023},
        '{1'b0, 32'd5,    10'd1023, 10'd1023},
        '{1'b1, 32'd8,    10'd8,    10'd8},
        '{1'b1, 32'd12,   10'd12,   10'd12},
        '{1'b1, 32'd30,   10'd30,   10'd30},
        '{1'b0, 32'd12,   10'd1023, 10'd30},
        '{1'b0, 32'd30,   10'd1023, 10'd8},
        '{1'b0, 32'd48,   10'd1023, 10'd8},
        '{1'b0, 32'hABC0_03FF, 10'd1023, 10'd8},
        '{1'b0, 32'hFFFF_FC08, 10'd1023, 10'd1023},
        '{1'b1, 32'd1,    10'd1,    10'd1},
        '{1'b1, 32'd2,    10'd2,    10'd2},
        '{1'b1, 32'd3,    10'd3,    10'd3},
        '{1'b1, 32'd4,    10'd4,    10'd4},
        '{1'b0, 32'd2,    10'd1023, 10'd4},
        '{1'b0, 32'd7,    10'd1023, 10'd4},
        '{1'b0, 32'd4,    10'd1023, 10'd3},
        '{1'b0, 32'd3,    10'd1023, 10'd1},
        '{1'b0, 32'd1,    10'd1023, 10'd1023},
        '{1'b1, 32'd47,   10'd47,   10'd47},
        '{1'b0, 32'd47,   10'd1023, 10'd1023}
    };

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 run_id", 32'(run_id), 32'(SPUR));
        chk("R1 run_prio", 32'(run_prio), 32'(IDLE_P));
        chk("R1 busy", 32'(busy), 0);
        chk("R1 pulses", {29'd0, ack_valid, clr_valid, repend_valid}, 0);

        // vector table: R2 R3 R5 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_ack) begin
                do_ack(VECS[i].arg[9:0], 1'b0);
                chk((VECS[i].exp_ack == SPUR) ? "R2 ack refused" : "R3 ack taken",
                    {21'd0, ack_valid, ack_id}, {21'd0, 1'b1, VECS[i].exp_ack});
            end else begin
                do_eoi(VECS[i].arg, 4'b0);
            end
            wait_idle();
            chk(VECS[i].is_ack ? "R11 run after ack" : "R7 R8 run after eoi",
                32'(run_id), 32'(VECS[i].exp_run));
            chk("R7 run_prio", 32'(run_prio),
                (VECS[i].exp_run == SPUR) ? 32'(IDLE_P) : 32'(prio_of(VECS[i].exp_run)));
        end

        // R4 clear mask, R6 re-pend, R5 ignored while idle
        do_ack(10'd9, 1'b1);
        chk("R4 clr 1-of-N", {17'd0, clr_valid, clr_id, clr_mask}, {17'd0, 1'b1, 10'd9, 4'hF});
        do_eoi(32'd9, 4'b1111);
        chk("R6 repend level", {21'd0, repend_valid, repend_id}, {21'd0, 1'b1, 10'd9});
        chk_run("R7 back to idle", SPUR);
        do_eoi(32'd9, 4'b1111);
        chk("R5 eoi idle no repend", 32'(repend_valid), 0);
        do_ack(10'd9, 1'b0);
        chk("R4 clr own cpu", {17'd0, clr_valid, clr_id, clr_mask}, {17'd0, 1'b1, 10'd9, 4'b0100});
        do_ack(10'd1023, 1'b1);
        chk("R2 refused no clear", 32'(clr_valid), 0);
        do_eoi(32'd9, 4'b0111);
        chk("R6 edge no repend", 32'(repend_valid), 0);
        do_ack(10'd9, 1'b0);
        do_eoi(32'd9, 4'b1101);
        chk("R6 line low no repend", 32'(repend_valid), 0);

        // R8 R9 deep walk with a request during busy
        for (int k = 1; k <= 5; k++) do_ack(10'(k), 1'b0);
        chk_run("R11 five deep", 10'd5);
        do_eoi(32'd1, 4'b0);
        chk("R8 busy during walk", 32'(busy), 1);
        ack_req = 1; pend_id = 10'd40; pend_prio = prio_of(10'd40);
        @(negedge clk);
        ack_req = 0;
        chk("R9 ack ignored while busy", 32'(ack_valid), 0);
        wait_idle();
        chk_run("R9 run unchanged", 10'd5);
        do_eoi(32'd5, 4'b0); chk_run("R8 pop 5", 10'd4);
        do_eoi(32'd4, 4'b0); chk_run("R8 pop 4", 10'd3);
        do_eoi(32'd3, 4'b0); chk_run("R8 pop 3", 10'd2);
        do_eoi(32'd2, 4'b0); chk_run("R8 spliced 1 skipped", SPUR);

        // R10 simultaneous requests
        do_ack(10'd6, 1'b0);
        @(negedge clk);
        ack_req = 1; pend_id = 10'd11; pend_prio = prio_of(10'd11);
        eoi_req = 1; eoi_data = 32'd6;
        @(negedge clk);
        ack_req = 0; eoi_req = 0;
        chk("R10 ack wins", {21'd0, ack_valid, ack_id}, {21'd0, 1'b1, 10'd11});
        wait_idle();
        chk_run("R10 run", 10'd11);
        do_eoi(32'd11, 4'b0); chk_run("R10 eoi dropped", 10'd6);
        do_eoi(32'd6, 4'b0);  chk_run("R7 final idle", SPUR);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule